// File: doc/BRIEF.md
# Tick-to-Timestamp Rational Converter

This block turns a raw tick count, taken from a free-running counter that advances by exactly one per cycle of a clock that need not run at 1 GHz, into an absolute time in nanoseconds. A reference pair is captured at one instant: the tick count, and the frame-timing time split into a nanosecond part and a picosecond remainder. It is captured together with a signed secondary offset. From these the block forms a base time. The base is the frame-timing nanoseconds, plus a fixed epoch shift of 315964819 seconds, minus the offset.

A conversion request supplies a tick value and the clock frequency in GHz as an integer ratio, numerator over denominator. For example, 950 MHz is 95/100 and 153.6 MHz is 1536/10000. The tick delta is scaled to picoseconds by one pass of a shared restoring divider. The picosecond remainder of the reference is folded in. A second pass of the same divider reduces the sum to whole nanoseconds. The result is a 64-bit timestamp with a one-cycle valid pulse.

A cycle timer raises a rebase request once too long has passed since the last capture. Rebasing keeps every intermediate value within 64 bits.

Top module: `tick_ts_conv`

## Requirements
- R1: After reset, busy, ts_valid, ts_err and rebase_req are low and ts_ns is zero.
- R2: A capture strobe stores the reference tick and the picosecond remainder (0 to 999). It also stores the base time, equal to the nanosecond input plus 315964819000000000 minus the sign-extended offset.
- R3: For a tick at or after the reference tick, the result is base + floor((rem_ps + S) / 1000), where S = floor(delta * den * 1000 / num) and delta = tick - reference tick.
- R4: For a tick before the reference tick, the result is floor((base*1000 + rem_ps - S) / 1000), with S formed from the magnitude of the delta. When S does not exceed rem_ps, the result equals the base.
- R5: A request accepted with a numerator of zero pulses ts_err for one cycle, in the cycle after acceptance. It produces no ts_valid and leaves busy low.
- R6: A request is accepted only while busy is low. busy is high from the cycle after acceptance until the cycle that carries ts_valid, and falls in that cycle. Requests raised while busy is high are ignored.
- R7: Each conversion uses the reference held at its acceptance. A capture made during a conversion, or in the same cycle as the request, applies only to later requests.
- R8: rebase_req rises once RESAMPLE_CYCLES clock cycles have passed since the last capture, and a capture clears it on the next edge.
- R9: ts_valid is high for exactly one cycle per result, and ts_ns changes only in a cycle where ts_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Reference capture strobe |
| cap_tick | input | 64 | Tick count at the capture instant |
| cap_ns | input | 64 | Frame-timing nanosecond part at the capture instant |
| cap_ps | input | 10 | Frame-timing picosecond remainder (0 to 999) |
| sec_off_ns | input | 32 | Signed secondary offset in ns, taken with the capture |
| freq_num | input | 16 | Clock frequency numerator (dividend of the GHz ratio) |
| freq_den | input | 16 | Clock frequency denominator (divisor of the GHz ratio) |
| req_valid | input | 1 | Conversion request |
| req_tick | input | 64 | Tick value to convert |
| busy | output | 1 | Conversion in progress |
| ts_valid | output | 1 | One-cycle result pulse |
| ts_ns | output | 64 | Converted timestamp in ns |
| ts_err | output | 1 | One-cycle pulse for a request with a zero numerator |
| rebase_req | output | 1 | Reference is due for recapture |

## Verification
The assertions assume that req_valid is not held high past the point where busy falls. They also assume that RESAMPLE_CYCLES is at least one, so that a capture always clears rebase_req. Both assumptions matter for the properties that link the fall of busy to ts_valid and to acceptance.

The bench drops each request after a single accepted cycle, and it raises requests during busy only for a few cycles early in a conversion. It keeps each tick delta small and each picosecond remainder below 1000, so that the scaled picosecond value stays within 64 bits, as periodic rebasing would guarantee in use.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCALE = 2'd1,
    ST_NORM  = 2'd2
  } conv_state_e;

  localparam longint unsigned EPOCH_SEC = 64'd315964819;
  localparam longint unsigned NS_PER_SEC = 64'd1000000000;
  localparam longint unsigned EPOCH_NS = EPOCH_SEC * NS_PER_SEC;
  localparam int unsigned PS_PER_NS = 1000;
  localparam int unsigned PS_SCALE_W = 10;

endpackage

// File: rtl/ttc_ref_store.sv
module ttc_ref_store
  import ttc_pkg::*;
#(
  parameter int TICK_W = 64,
  parameter int OFF_W = 32,
  parameter int PS_W = 10,
  parameter longint unsigned RESAMPLE_CYCLES = 64'd1800000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [TICK_W-1:0] cap_tick,
  input  logic [TICK_W-1:0] cap_ns,
  input  logic [PS_W-1:0]   cap_ps,
  input  logic [OFF_W-1:0]  sec_off_ns,
  output logic [TICK_W-1:0] ref_tick,
  output logic [TICK_W-1:0] ref_base_ns,
  output logic [PS_W-1:0]   ref_ps,
  output logic              rebase_req
);

  localparam int CNT_W = $clog2(RESAMPLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RESAMPLE_CYCLES);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [TICK_W-1:0] base_q, base_d;
  logic [PS_W-1:0]   ps_q, ps_d;
  logic [CNT_W-1:0]  age_q, age_d;
  logic [TICK_W-1:0] off_ext;

  // sign extension of the secondary offset
  assign off_ext = TICK_W'($signed(sec_off_ns));

  always_comb begin
    tick_d = tick_q;
    base_d = base_q;
    ps_d   = ps_q;
    age_d  = age_q;
    if (cap_valid) begin
      tick_d = cap_tick;
      base_d = cap_ns + TICK_W'(EPOCH_NS) - off_ext;
      ps_d   = cap_ps;
      age_d  = '0;
    end else if (age_q != CNT_LIM) begin
      age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      base_q <= '0;
      ps_q   <= '0;
      age_q  <= '0;
    end else begin
      tick_q <= tick_d;
      base_q <= base_d;
      ps_q   <= ps_d;
      age_q  <= age_d;
    end
  end

  assign ref_tick    = tick_q;
  assign ref_base_ns = base_q;
  assign ref_ps      = ps_q;
  assign rebase_req  = (age_q == CNT_LIM);

endmodule

// File: rtl/ttc_divider.sv
module ttc_divider #(
  parameter int DW = 90,
  parameter int VW = 16,
  parameter int QW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [QW-1:0] quotient
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] rem_q, rem_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [VW-1:0] dvs_q, dvs_d;
  logic [VW:0]   trial;

  // one quotient bit per cycle, MSB first
  always_comb begin
    run_d  = run_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    trial  = {rem_q, quo_q[DW-1]};
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
    end else if (run_q) begin
      if (trial >= {1'b0, dvs_q}) begin
        rem_d = VW'(trial - {1'b0, dvs_q});
        quo_d = {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_d = trial[VW-1:0];
        quo_d = {quo_q[DW-2:0], 1'b0};
      end
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q[QW-1:0];

endmodule

// File: rtl/tick_ts_conv.sv
module tick_ts_conv
  import ttc_pkg::*;
#(
  parameter int TICK_W = 64,
  parameter int FREQ_W = 16,
  parameter int OFF_W = 32,
  parameter int PS_W = 10,
  parameter longint unsigned RESAMPLE_CYCLES = 64'd1800000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [TICK_W-1:0] cap_tick,
  input  logic [TICK_W-1:0] cap_ns,
  input  logic [PS_W-1:0]   cap_ps,
  input  logic [OFF_W-1:0]  sec_off_ns,
  input  logic [FREQ_W-1:0] freq_num,
  input  logic [FREQ_W-1:0] freq_den,
  input  logic              req_valid,
  input  logic [TICK_W-1:0] req_tick,
  output logic              busy,
  output logic              ts_valid,
  output logic [TICK_W-1:0] ts_ns,
  output logic              ts_err,
  output logic              rebase_req
);

  localparam int DW = TICK_W + FREQ_W + PS_SCALE_W;

  logic [TICK_W-1:0] ref_tick, ref_base_ns;
  logic [PS_W-1:0]   ref_ps;

  ttc_ref_store #(
    .TICK_W(TICK_W), .OFF_W(OFF_W), .PS_W(PS_W), .RESAMPLE_CYCLES(RESAMPLE_CYCLES)
  ) i_ref (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_tick(cap_tick),
    .cap_ns(cap_ns), .cap_ps(cap_ps), .sec_off_ns(sec_off_ns),
    .ref_tick(ref_tick), .ref_base_ns(ref_base_ns), .ref_ps(ref_ps),
    .rebase_req(rebase_req)
  );

  logic              div_start, div_done;
  logic [DW-1:0]     div_dvd;
  logic [FREQ_W-1:0] div_dvs;
  logic [TICK_W-1:0] div_quo;

  ttc_divider #(.DW(DW), .VW(FREQ_W), .QW(TICK_W)) i_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_dvd),
    .divisor(div_dvs), .done(div_done), .quotient(div_quo)
  );

  conv_state_e       state_q, state_d;
  logic              neg_q, neg_d;
  logic [TICK_W-1:0] base_q, base_d;
  logic [PS_W-1:0]   rps_q, rps_d;
  logic [TICK_W-1:0] ts_q, ts_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  logic              accept, req_neg;
  logic [TICK_W-1:0] mag, rps_ext, sum_pos, sum_neg;
  logic [DW-1:0]     scale_dvd;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign req_neg   = req_tick < ref_tick;
  assign mag       = req_neg ? (ref_tick - req_tick) : (req_tick - ref_tick);
  assign scale_dvd = DW'(mag) * DW'(freq_den) * DW'(PS_PER_NS);
  assign rps_ext   = TICK_W'(rps_q);
  assign sum_pos   = div_quo + rps_ext;
  // ceiling of (scaled - remainder) / 1000 taken through a floor division
  assign sum_neg   = div_quo - rps_ext + TICK_W'(PS_PER_NS - 1);

  always_comb begin
    state_d   = state_q;
    neg_d     = neg_q;
    base_d    = base_q;
    rps_d     = rps_q;
    ts_d      = ts_q;
    vld_d     = 1'b0;
    err_d     = 1'b0;
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = FREQ_W'(PS_PER_NS);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (freq_num == '0) begin
            err_d = 1'b1;
          end else begin
            div_start = 1'b1;
            div_dvd   = scale_dvd;
            div_dvs   = freq_num;
            neg_d     = req_neg;
            base_d    = ref_base_ns;
            rps_d     = ref_ps;
            state_d   = ST_SCALE;
          end
        end
      end
      ST_SCALE: begin
        if (div_done) begin
          if (!neg_q) begin
            div_start = 1'b1;
            div_dvd   = DW'(sum_pos);
            state_d   = ST_NORM;
          end else if (div_quo <= rps_ext) begin
            ts_d    = base_q;
            vld_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            div_start = 1'b1;
            div_dvd   = DW'(sum_neg);
            state_d   = ST_NORM;
          end
        end
      end
      ST_NORM: begin
        if (div_done) begin
          ts_d    = neg_q ? (base_q - div_quo) : (base_q + div_quo);
          vld_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      neg_q   <= 1'b0;
      base_q  <= '0;
      rps_q   <= '0;
      ts_q    <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      neg_q   <= neg_d;
      base_q  <= base_d;
      rps_q   <= rps_d;
      ts_q    <= ts_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign ts_valid = vld_q;
  assign ts_ns    = ts_q;
  assign ts_err   = err_q;

endmodule

// File: rtl/tick_ts_conv_chk.sv
module tick_ts_conv_chk #(
  parameter int TICK_W = 64,
  parameter int FREQ_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_valid,
  input logic              req_valid,
  input logic [FREQ_W-1:0] freq_num,
  input logic              busy,
  input logic              ts_valid,
  input logic [TICK_W-1:0] ts_ns,
  input logic              ts_err,
  input logic              rebase_req
);

  // R5
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_err |-> (!ts_valid && !busy));

  // R5
  err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_err |-> ($past(req_valid) && !$past(busy) && ($past(freq_num) == '0)));

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (freq_num != '0)) |=> busy);

  // R6
  busy_fall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ts_valid);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> !ts_valid);

  // R9
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts_ns) |-> ts_valid);

  // R8
  rebase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !rebase_req);

endmodule

bind tick_ts_conv tick_ts_conv_chk #(.TICK_W(TICK_W), .FREQ_W(FREQ_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .req_valid(req_valid),
  .freq_num(freq_num), .busy(busy), .ts_valid(ts_valid), .ts_ns(ts_ns),
  .ts_err(ts_err), .rebase_req(rebase_req)
);

// File: tb/test_tick_ts_conv.sv
module test_tick_ts_conv;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned LIM = 64'd300;
  localparam int NV = 8;

  localparam logic [63:0] V_TICK [NV] = '{
    64'd1000000, 64'd1000950, 64'd1000001, 64'd2000000,
    64'd1099511627776 + 64'd1000000, 64'd999000, 64'd999999, 64'd1012345
  };
  localparam logic [15:0] V_NUM [NV] = '{
    16'd95, 16'd95, 16'd95, 16'd1536, 16'd1, 16'd95, 16'd3, 16'd1000
  };
  localparam logic [15:0] V_DEN [NV] = '{
    16'd100, 16'd100, 16'd100, 16'd10000, 16'd1, 16'd100, 16'd7, 16'd1000
  };

  logic clk, rst_n, cap_valid, req_valid;
  logic [63:0] cap_tick, cap_ns, req_tick;
  logic [9:0] cap_ps;
  logic [31:0] sec_off_ns;
  logic [15:0] freq_num, freq_den;
  logic busy, ts_valid, ts_err, rebase_req;
  logic [63:0] ts_ns;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [63:0] r_tick, r_ns;
  logic [9:0] r_ps;
  logic [31:0] r_off;

  tick_ts_conv #(.RESAMPLE_CYCLES(LIM)) i_tick_ts_conv (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_tick(cap_tick),
    .cap_ns(cap_ns), .cap_ps(cap_ps), .sec_off_ns(sec_off_ns),
    .freq_num(freq_num), .freq_den(freq_den), .req_valid(req_valid),
    .req_tick(req_tick), .busy(busy), .ts_valid(ts_valid), .ts_ns(ts_ns),
    .ts_err(ts_err), .rebase_req(rebase_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [63:0] model(input logic [63:0] tick, rtick, rns,
                                        input logic [9:0] rps, input logic [31:0] off,
                                        input logic [15:0] num, den);
    logic signed [127:0] b, o, m, sc, tot;
    o = 128'($signed(off));
    b = $signed({64'd0, rns}) + 128'sd315964819000000000 - o;
    b = b * 128'sd1000 + $signed({118'd0, rps});
    if (tick >= rtick) m = $signed({64'd0, tick - rtick});
    else m = $signed({64'd0, rtick - tick});
    sc = m * $signed({112'd0, den}) * 128'sd1000 / $signed({112'd0, num});
    tot = (tick >= rtick) ? b + sc : b - sc;
    return 64'(tot / 128'sd1000);
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic capture(input logic [63:0] t, ns, input logic [9:0] ps, input logic [31:0] off);
    @(negedge clk);
    cap_tick = t; cap_ns = ns; cap_ps = ps; sec_off_ns = off; cap_valid = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0;
    r_tick = t; r_ns = ns; r_ps = ps; r_off = off;
  endtask

  task automatic wait_result(output logic ok, output logic [63:0] ts);
    ok = 1'b0; ts = '0;
    for (int i = 0; i < 400; i++) begin
      if (ts_valid) begin ok = 1'b1; ts = ts_ns; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_req(input logic [63:0] t, input logic [15:0] num, den,
                         output logic ok, output logic [63:0] ts, output logic err);
    @(negedge clk);
    req_tick = t; freq_num = num; freq_den = den; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    err = ts_err;
    wait_result(ok, ts);
  endtask

  initial begin
    logic ok, err;
    logic [63:0] ts, exp, hold;
    logic [63:0] a_tick, a_ns;
    logic [9:0] a_ps;
    logic [31:0] a_off;
    int pulses;
    rst_n = 1'b0; cap_valid = 1'b0; req_valid = 1'b0;
    cap_tick = '0; cap_ns = '0; cap_ps = '0; sec_off_ns = '0;
    freq_num = 16'd1; freq_den = 16'd1; req_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 ts_valid", 64'(ts_valid), 64'd0);
    check("R1 ts_err", 64'(ts_err), 64'd0);
    check("R1 rebase_req", 64'(rebase_req), 64'd0);
    check("R1 ts_ns", ts_ns, 64'd0);

    // R2 R3 R4 table of vectors on one reference, negative offset
    capture(64'd1000000, 64'd5000000123, 10'd456, -32'sd250);
    for (int v = 0; v < NV; v++) begin
      run_req(V_TICK[v], V_NUM[v], V_DEN[v], ok, ts, err);
      exp = model(V_TICK[v], r_tick, r_ns, r_ps, r_off, V_NUM[v], V_DEN[v]);
      check("R3/R4 valid", 64'(ok), 64'd1);
      check(V_TICK[v] >= r_tick ? "R3 value" : "R4 value", ts, exp);
      @(negedge clk);
      // R9 single pulse, value held
      check("R9 pulse", 64'(ts_valid), 64'd0);
      check("R9 hold", ts_ns, ts);
    end

    // R2 positive offset with direct expected base (zero delta, zero remainder)
    capture(64'd77, 64'd1000, 10'd0, 32'd400);
    run_req(64'd77, 16'd95, 16'd100, ok, ts, err);
    check("R2 base", ts, 64'd315964819000000000 + 64'd600);

    // R4 small negative delta stays at base
    capture(64'd5000, 64'd9000, 10'd456, 32'd0);
    run_req(64'd4999, 16'd1000, 16'd1, ok, ts, err);
    check("R4 small", ts, 64'd315964819000000000 + 64'd9000);

    // R5 zero numerator
    hold = ts_ns;
    run_req(64'd6000, 16'd0, 16'd1, ok, ts, err);
    check("R5 err pulse", 64'(err), 64'd1);
    check("R5 no valid", 64'(ok), 64'd0);
    check("R5 ts held", ts_ns, hold);

    // R7 capture during a conversion
    a_tick = r_tick; a_ns = r_ns; a_ps = r_ps; a_off = r_off;
    @(negedge clk);
    req_tick = 64'd7000; freq_num = 16'd95; freq_den = 16'd100; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cap_tick = 64'd6500; cap_ns = 64'd123456; cap_ps = 10'd999; sec_off_ns = 32'd17; cap_valid = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0;
    r_tick = 64'd6500; r_ns = 64'd123456; r_ps = 10'd999; r_off = 32'd17;
    wait_result(ok, ts);
    check("R7 old ref", ts, model(64'd7000, a_tick, a_ns, a_ps, a_off, 16'd95, 16'd100));
    run_req(64'd7000, 16'd95, 16'd100, ok, ts, err);
    check("R7 new ref", ts, model(64'd7000, r_tick, r_ns, r_ps, r_off, 16'd95, 16'd100));

    // R7 capture in the same cycle as the request
    a_tick = r_tick; a_ns = r_ns; a_ps = r_ps; a_off = r_off;
    @(negedge clk);
    req_tick = 64'd8000; req_valid = 1'b1;
    cap_tick = 64'd1; cap_ns = 64'd2; cap_ps = 10'd3; sec_off_ns = 32'd4; cap_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; cap_valid = 1'b0;
    r_tick = 64'd1; r_ns = 64'd2; r_ps = 10'd3; r_off = 32'd4;
    wait_result(ok, ts);
    check("R7 same cycle", ts, model(64'd8000, a_tick, a_ns, a_ps, a_off, 16'd95, 16'd100));

    // R6 requests while busy are ignored
    @(negedge clk);
    req_tick = 64'd9000; freq_num = 16'd1536; freq_den = 16'd10000; req_valid = 1'b1;
    @(negedge clk);
    check("R6 busy high", 64'(busy), 64'd1);
    req_tick = 64'd12345;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    pulses = 0; ts = '0;
    for (int i = 0; i < 450; i++) begin
      if (ts_valid) begin pulses++; ts = ts_ns; end
      @(negedge clk);
    end
    check("R6 one result", 64'(pulses), 64'd1);
    check("R6 first request", ts, model(64'd9000, r_tick, r_ns, r_ps, r_off, 16'd1536, 16'd10000));
    check("R6 idle after", 64'(busy), 64'd0);

    // R8 rebase timer
    capture(64'd10, 64'd20, 10'd30, 32'd0);
    check("R8 cleared", 64'(rebase_req), 64'd0);
    repeat (int'(LIM) - 1) @(negedge clk);
    check("R8 before limit", 64'(rebase_req), 64'd0);
    @(negedge clk);
    check("R8 at limit", 64'(rebase_req), 64'd1);
    capture(64'd10, 64'd20, 10'd30, 32'd0);
    check("R8 recapture", 64'(rebase_req), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule